// File: doc/BRIEF.md
# Maskable Edge Interrupt Controller

This block gathers five interrupt sources into a single interrupt line. Each source owns a sticky status bit. The status bit stays set until software clears it. The sources, by bit position, are:

- bit 0: core interrupt
- bit 1: hot-plug rise
- bit 2: hot-plug fall
- bit 3: nonce-refresh rise
- bit 4: random-number error

The core interrupt is a level signal. Only its low-to-high transition records an event. The other four inputs are event strobes: any cycle in which one of them is high sets its bit.

Software reaches the block through a plain register port with one-cycle read latency. There are three registers:

- An enable mask. A 1 in a bit lets that source drive the output.
- A status register. A read returns the sticky bits plus the live core level. Writing a 1 forces the matching bit set.
- A clear register. Writing a 1 clears the matching status bit.

The interrupt output is the OR of all status bits gated by their enable bits. It is not registered after the status and mask flops, so it follows them in the same cycle.

The register port is control traffic, so it carries no valid/ready handshake:

- A write takes effect at the clock edge where `reg_wr_i` is high.
- Read data appears on the edge where `reg_rd_i` is high. It holds until the next read.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the mask and status are zero, `irq_o` is low and `reg_rdata_o` is zero.
- R2: Status bit 0 is set only on a rising edge of `src_i[0]`. If `src_i[0]` is held high after its bit is cleared, the bit is not set again.
- R3: Status bits 1 to 4 are set at every clock edge where the matching `src_i` bit is high.
- R4: A status bit, once set, stays set after its source returns low, until a clear write removes it.
- R5: Writing to address 1 (status) sets every status bit `i` whose `reg_wdata_i[i]` is 1. Zero bits, and bits 5 and above, have no effect.
- R6: Writing to address 2 (clear) clears every status bit `i` whose `reg_wdata_i[i]` is 1. Zero bits have no effect.
- R7: When a source sets a bit in the same cycle that a clear write targets it, the bit ends up set.
- R8: Address 0 holds the 5-bit enable mask (1 = enabled). Bits 5 and above of the write are dropped and read back as 0. `irq_o` is high exactly when some status bit and its mask bit are both 1.
- R9: A status read returns the status in bits 4:0, the live level of `src_i[0]` at the read edge in bit 31, and zeros in bits 30:5.
- R10: Read data is registered on the edge where `reg_rd_i` is high and holds until the next read. Addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 5 | Interrupt sources, bit 0 = core level, bits 1-4 = event strobes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 status, 2 clear, 3 reserved |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a clear write and a hardware set landing on the same bit in the same edge. The stimulus raises an event strobe at the same falling edge where it drives a clear of all bits, so both meet at one rising edge.

The other delicate case is a core level that stays high across a clear. The stimulus clears bit 0 while the core input remains asserted, waits several cycles, and then reads. This shows that no second event was recorded and that bit 31 still reports the level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_ADDR_W = 2;

  typedef enum logic [IRQ_ADDR_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_cond.sv
// Per-source conditioning: edge detect or pass-through, picked per bit.
module irq_src_cond #(
  parameter int              NUM_SRC  = 5,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 5'b00001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] hit_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (EDGE_SRC[g]) begin : g_edge
      logic prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[g];
      end

      assign hit_o[g] = src_i[g] & ~prev_q;
    end else begin : g_level
      assign hit_o[g] = src_i[g];
    end
  end
endmodule

// File: rtl/irq_status.sv
// Sticky status bits; a hardware or software set beats a clear.
module irq_status #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_set_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] stat_d;

  always_comb stat_d = (stat_o & ~sw_clr_i) | hw_set_i | sw_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= stat_d;
  end
endmodule

// File: rtl/irq_regif.sv
// Register decode, enable mask storage and registered read mux.
module irq_regif
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [IRQ_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  input  logic [NUM_SRC-1:0]    stat_i,
  input  logic                  core_lvl_i,
  output logic [NUM_SRC-1:0]    mask_o,
  output logic [NUM_SRC-1:0]    sw_set_o,
  output logic [NUM_SRC-1:0]    sw_clr_o,
  output logic [DATA_W-1:0]     rdata_o
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wbits;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign sel          = reg_sel_e'(reg_addr_i);
  assign wbits        = reg_wdata_i[NUM_SRC-1:0];
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_SRC];

  assign sw_set_o = (reg_wr_i && sel == SEL_STAT) ? wbits : '0;
  assign sw_clr_o = (reg_wr_i && sel == SEL_CLR)  ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_o <= '0;
    else if (reg_wr_i && sel == SEL_MASK) mask_o <= wbits;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MASK: rd_mux[NUM_SRC-1:0] = mask_o;
      SEL_STAT: begin
        rd_mux[NUM_SRC-1:0] = stat_i;
        rd_mux[DATA_W-1]    = core_lvl_i;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_o <= '0;
    else if (reg_rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_pkg::*;
#(
  parameter int                 NUM_SRC  = 5,
  parameter int                 DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 5'b00001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [IRQ_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  logic [NUM_SRC-1:0] hit_w;
  logic [NUM_SRC-1:0] stat_w;
  logic [NUM_SRC-1:0] mask_w;
  logic [NUM_SRC-1:0] sw_set_w;
  logic [NUM_SRC-1:0] sw_clr_w;

  irq_src_cond #(.NUM_SRC(NUM_SRC), .EDGE_SRC(EDGE_SRC)) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .hit_o (hit_w)
  );

  irq_status #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set_i (hit_w),
    .sw_set_i (sw_set_w),
    .sw_clr_i (sw_clr_w),
    .stat_o   (stat_w)
  );

  irq_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .stat_i      (stat_w),
    .core_lvl_i  (src_i[0]),
    .mask_o      (mask_w),
    .sw_set_o    (sw_set_w),
    .sw_clr_o    (sw_clr_w),
    .rdata_o     (reg_rdata_o)
  );

  assign irq_o = |(stat_w & mask_w);
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk #(
  parameter int                 NUM_SRC  = 5,
  parameter int                 DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 5'b00001
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               reg_wr_i,
  input logic               reg_rd_i,
  input logic [1:0]         reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_w,
  input logic [NUM_SRC-1:0] mask_w
);
  localparam logic [NUM_SRC-1:0] LVL_SRC = ~EDGE_SRC;

  logic [NUM_SRC-1:0] clr_req;
  logic [NUM_SRC-1:0] lvl_req;

  assign clr_req = (reg_wr_i && reg_addr_i == 2'd2) ? reg_wdata_i[NUM_SRC-1:0] : '0;
  assign lvl_req = src_i & LVL_SRC;

  assert_core_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[0] && !$past(src_i[0])) |=> stat_w[0]);

  assert_level_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req != '0) |=> ((stat_w & $past(lvl_req)) == $past(lvl_req)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_w & $past(stat_w & ~clr_req)) == $past(stat_w & ~clr_req)));

  assert_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd1) |=>
      ((stat_w & $past(reg_wdata_i[NUM_SRC-1:0])) == $past(reg_wdata_i[NUM_SRC-1:0])));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & lvl_req) != '0) |=> ((stat_w & $past(clr_req & lvl_req)) != '0));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((stat_w & mask_w) != '0));

  assert_raw_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == 2'd1) |=> (reg_rdata_o[DATA_W-1] == $past(src_i[0])));
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EDGE_SRC(EDGE_SRC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_i       (src_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .stat_w      (stat_w),
  .mask_w      (mask_w)
);

// File: tb/irq_edge_ctrl_bench.sv
module irq_edge_ctrl_bench;
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;
  localparam logic [1:0] A_RSVD = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_vec = 0;
  int n_err = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  irq_edge_ctrl u_irq_edge_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: one expected item per read, compared the cycle after the read edge.
  always @(posedge clk) rd_seen <= reg_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(reg_rdata, 32'hxxxx_xxxx, "scoreboard underflow");
      end else begin
        check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // Driver tasks. Each is entered and left on a falling edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_seq();
    idle(3);
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    check(reg_rdata, 32'd0, "R1 rdata after reset");
    rst_n = 1'b1;
    idle(1);
    rd_exp(A_STAT, 32'h0, "R1 status reset");
    rd_exp(A_MASK, 32'h0, "R1 mask reset");

    // R3 / R4: one-cycle strobe on hot-plug rise, sticky afterwards
    src = 5'b00010; idle(1); src = '0; idle(1);
    rd_exp(A_STAT, 32'h2, "R3 R4 strobe sticky");
    check({31'd0, irq}, 32'd0, "R8 masked off");

    // R8: mask enable and read-back, upper bits dropped
    wr(A_MASK, 32'hFFFF_FFFF);
    check({31'd0, irq}, 32'd1, "R8 irq enabled");
    rd_exp(A_MASK, 32'h1F, "R8 mask readback");

    // R6: zero clear has no effect, then real clear
    wr(A_CLR, 32'h0);
    rd_exp(A_STAT, 32'h2, "R6 zero clear");
    wr(A_CLR, 32'h2);
    check({31'd0, irq}, 32'd0, "R6 irq after clear");
    rd_exp(A_STAT, 32'h0, "R6 cleared");

    // R2 / R9: core edge latching and raw level in bit 31
    src = 5'b00001; idle(1);
    rd_exp(A_STAT, 32'h8000_0001, "R2 R9 core edge");
    wr(A_CLR, 32'h1); idle(2);
    rd_exp(A_STAT, 32'h8000_0000, "R2 held level no reset");
    src = '0; idle(1);
    rd_exp(A_STAT, 32'h0, "R9 level low");
    src = 5'b00001; idle(1);
    rd_exp(A_STAT, 32'h8000_0001, "R2 second edge");
    src = '0; wr(A_CLR, 32'h1);

    // R5: software set
    wr(A_STAT, 32'h0);
    rd_exp(A_STAT, 32'h0, "R5 zero set");
    wr(A_STAT, 32'h14);
    rd_exp(A_STAT, 32'h14, "R5 set bits");
    wr(A_STAT, 32'hFFFF_FFE0);
    rd_exp(A_STAT, 32'h14, "R5 upper bits ignored");

    // R7: hardware set collides with clear of all bits
    src = 5'b01000;
    wr(A_CLR, 32'h1F);
    src = '0;
    rd_exp(A_STAT, 32'h8, "R7 set wins");

    // R8: selective mask
    wr(A_MASK, 32'h04);
    check({31'd0, irq}, 32'd0, "R8 unmasked bit only set elsewhere");
    wr(A_STAT, 32'h4);
    check({31'd0, irq}, 32'd1, "R8 enabled bit raises irq");
    wr(A_CLR, 32'h1F);
    check({31'd0, irq}, 32'd0, "R8 irq drops");

    // R10: reserved/clear read as zero, data holds between reads
    wr(A_STAT, 32'h3);
    rd_exp(A_CLR, 32'h0, "R10 clear addr reads zero");
    rd_exp(A_RSVD, 32'h0, "R10 reserved reads zero");
    rd_exp(A_MASK, 32'h04, "R10 mask read");
    wr(A_MASK, 32'h0);
    idle(3);
    check(reg_rdata, 32'h04, "R10 rdata holds");
    idle(2);
    check(exp_q.size(), 32'd0, "scoreboard drained");
  endtask

  initial begin
    fork
      run_seq();
      begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule